// File: doc/BRIEF.md
# Telegram Frame Synchronizer and Decoder

This block sits after a baseband demodulator. Each incoming symbol arrives with a one-cycle valid strobe. The block first waits for a run of alternating symbols that is long enough to count as a wake-up preamble. It then compares the recent symbol history against a programmable start-of-frame pattern. When that pattern matches exactly, the block locks onto the frame and decodes the payload in NRZ or Manchester form.

Decoded bits are packed into bytes, most significant bit first. Each byte is released with a one-cycle valid pulse. An 8-bit CRC runs over the payload bits, and a programmable number of leading bits can be left out of it. The byte that follows the payload carries the received CRC. This byte is compared against the computed value and is not itself released. A Manchester coding violation inside the payload aborts the frame and sends the block back to wake-up search. After the CRC byte, the frame is closed, and later symbols (for example a stop sequence) are not accepted as data.

Top module: `tlg_deframer`

## Requirements
- R1: After reset, byte_valid_o, frame_start_o, frame_end_o, abort_o and crc_ok_o are all 0.
- R2: The start pattern is only searched for after at least wake_min_i consecutive symbols have arrived in which each symbol differs from the one before it, the first symbol of the run included. With a shorter run, a following start pattern and payload produce no frame_start_o and no bytes.
- R3: Only the low sof_len_i bits of sof_pat_i (1 to 32) form the start pattern. Bit sof_len_i-1 is the earliest symbol received. All bits must match exactly. On a match, frame_start_o pulses for one cycle, in the cycle after the last pattern symbol's strobe. A pattern with one wrong symbol yields no frame_start_o.
- R4: With manch_en_i=0 (NRZ), each payload symbol is one data bit equal to the symbol value.
- R5: With manch_en_i=1, two symbols form one bit. If manch_pol_i=0, the sequence 0 then 1 is a logic 1 and 1 then 0 is a logic 0. If manch_pol_i=1, the mapping is reversed.
- R6: Exactly pay_len_i bytes (1 to 64) are released per frame. Each byte is assembled MSB first, and byte_valid_o is a one-cycle pulse per byte.
- R7: The CRC uses polynomial 0x07 (x^8+x^2+x+1). It shifts MSB first and starts from crc_init_i. It covers the payload bits whose index, counted from 0 at the first payload bit, is at least crc_skip_i. The byte after the payload is the received CRC. crc_ok_o, valid while frame_end_o is high and held until the next frame end, is 1 only if the two are equal.
- R8: In Manchester mode, two equal symbols within one bit are a violation. A violation pulses abort_o, releases no further bytes, gives no frame_end_o, and returns the block to wake-up search.
- R9: frame_end_o pulses once, in the cycle after the last symbol of the CRC byte. Symbols that follow produce no bytes until a new wake-up run and start pattern are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 1 | Demodulated symbol |
| sym_valid_i | input | 1 | Symbol strobe, one cycle per symbol |
| manch_en_i | input | 1 | 1 selects Manchester payload, 0 selects NRZ |
| manch_pol_i | input | 1 | Manchester polarity (see R5) |
| wake_min_i | input | 16 | Minimum length of the alternating wake-up run |
| sof_pat_i | input | 32 | Start-of-frame pattern, right aligned |
| sof_len_i | input | 6 | Start pattern length in symbols, 1 to 32 |
| pay_len_i | input | 7 | Payload length in bytes, 1 to 64 |
| crc_skip_i | input | 6 | Leading payload bits left out of the CRC |
| crc_init_i | input | 8 | CRC initial value |
| byte_o | output | 8 | Received payload byte |
| byte_valid_o | output | 1 | One-cycle pulse, byte_o valid |
| frame_start_o | output | 1 | One-cycle pulse on start pattern match |
| frame_end_o | output | 1 | One-cycle pulse after the CRC byte |
| crc_ok_o | output | 1 | CRC comparison result |
| abort_o | output | 1 | One-cycle pulse on a Manchester violation |

## Verification
The assertions assume the following about the inputs. sym_valid_i is a single-cycle strobe. The configuration inputs stay constant while a frame is in progress. sof_len_i, pay_len_i and wake_min_i stay within their stated ranges. Each directed task sets up the configuration before it sends the first wake-up symbol and changes it only between frames. Every symbol strobe is followed by an idle cycle. Start patterns begin with two equal symbols, so no part of the alternating preamble can be mistaken for the pattern.

// File: rtl/tlg_pkg.sv
package tlg_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_SOF, ST_PAY} tlg_state_e;

  localparam logic [7:0] CRC_POLY = 8'h07;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic b);
    logic fb;
    fb = crc[7] ^ b;
    return {crc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/tlg_wake_det.sv
module tlg_wake_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sym_valid_i,
  input  logic             sym_i,
  output logic [CNT_W-1:0] run_o
);
  logic prev_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (clr_i) begin
      run_q <= '0;
    end else if (sym_valid_i) begin
      prev_q <= sym_i;
      if (run_q != '0 && sym_i != prev_q) begin
        if (run_q != '1) run_q <= run_q + 1'b1;
      end else begin
        run_q <= CNT_W'(1);
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/tlg_sof_match.sv
module tlg_sof_match #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_valid_i,
  input  logic          sym_i,
  input  logic [W-1:0]  pat_i,
  input  logic [LW-1:0] len_i,
  output logic          hit_o
);
  logic [W-1:0] sh_q, sh_d, mask;

  assign sh_d = {sh_q[W-2:0], sym_i};

  always_comb begin
    if (len_i >= LW'(W)) mask = '1;
    else                 mask = (W'(1) << len_i) - W'(1);
  end

  // compare against the history including the current symbol
  assign hit_o = sym_valid_i && ((sh_d & mask) == (pat_i & mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sh_q <= '0;
    else if (sym_valid_i) sh_q <= sh_d;
  end
endmodule

// File: rtl/tlg_sym_dec.sv
module tlg_sym_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic manch_i,
  input  logic pol_i,
  input  logic sym_valid_i,
  input  logic sym_i,
  output logic bit_v_o,
  output logic bit_o,
  output logic viol_o
);
  logic half_q, first_q;

  always_comb begin
    bit_v_o = 1'b0;
    bit_o   = sym_i;
    viol_o  = 1'b0;
    if (active_i && sym_valid_i) begin
      if (!manch_i) begin
        bit_v_o = 1'b1;
      end else if (half_q) begin
        if (sym_i == first_q) begin
          viol_o = 1'b1;
        end else begin
          bit_v_o = 1'b1;
          bit_o   = pol_i ? first_q : ~first_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (!active_i) begin
      half_q <= 1'b0;
    end else if (sym_valid_i && manch_i) begin
      half_q <= ~half_q;
      if (!half_q) first_q <= sym_i;
    end
  end
endmodule

// File: rtl/tlg_deframer.sv
module tlg_deframer #(
  parameter int SOF_W   = 32,
  parameter int WAKE_W  = 16,
  parameter int MAX_LEN = 64,
  parameter int SKIP_W  = 6,
  parameter int SOF_LW  = $clog2(SOF_W + 1),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_i,
  input  logic              sym_valid_i,
  input  logic              manch_en_i,
  input  logic              manch_pol_i,
  input  logic [WAKE_W-1:0] wake_min_i,
  input  logic [SOF_W-1:0]  sof_pat_i,
  input  logic [SOF_LW-1:0] sof_len_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic [SKIP_W-1:0] crc_skip_i,
  input  logic [7:0]        crc_init_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              crc_ok_o,
  output logic              abort_o
);
  import tlg_pkg::*;

  localparam int BIDX_W = LEN_W + 3;

  tlg_state_e        state_q;
  logic [WAKE_W-1:0] run;
  logic              sof_hit, bit_v, bit_val, viol;
  logic [2:0]        bit_cnt_q;
  logic [LEN_W-1:0]  byte_idx_q;
  logic [7:0]        sh_q, crc_q, byte_nxt;
  logic              in_pay, crc_take;

  tlg_wake_det #(.CNT_W(WAKE_W)) u_wake (
    .clk_i, .rst_ni,
    .clr_i       (state_q != ST_HUNT),
    .sym_valid_i,
    .sym_i,
    .run_o       (run)
  );

  tlg_sof_match #(.W(SOF_W), .LW(SOF_LW)) u_sof (
    .clk_i, .rst_ni, .sym_valid_i, .sym_i,
    .pat_i (sof_pat_i),
    .len_i (sof_len_i),
    .hit_o (sof_hit)
  );

  tlg_sym_dec u_dec (
    .clk_i, .rst_ni,
    .active_i    (state_q == ST_PAY),
    .manch_i     (manch_en_i),
    .pol_i       (manch_pol_i),
    .sym_valid_i,
    .sym_i,
    .bit_v_o     (bit_v),
    .bit_o       (bit_val),
    .viol_o      (viol)
  );

  assign byte_nxt = {sh_q[6:0], bit_val};
  assign in_pay   = byte_idx_q < pay_len_i;
  assign crc_take = in_pay && ({byte_idx_q, bit_cnt_q} >= BIDX_W'(crc_skip_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_HUNT;
      bit_cnt_q     <= '0;
      byte_idx_q    <= '0;
      sh_q          <= '0;
      crc_q         <= '0;
      byte_o        <= '0;
      byte_valid_o  <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      crc_ok_o      <= 1'b0;
      abort_o       <= 1'b0;
    end else begin
      byte_valid_o  <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      abort_o       <= 1'b0;
      unique case (state_q)
        ST_HUNT: if (run >= wake_min_i) state_q <= ST_SOF;
        ST_SOF: if (sof_hit) begin
          state_q       <= ST_PAY;
          frame_start_o <= 1'b1;
          crc_q         <= crc_init_i;
          bit_cnt_q     <= '0;
          byte_idx_q    <= '0;
        end
        ST_PAY: begin
          if (viol) begin
            abort_o <= 1'b1;
            state_q <= ST_HUNT;
          end else if (bit_v) begin
            sh_q      <= byte_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (crc_take) crc_q <= crc8_step(crc_q, bit_val);
            if (bit_cnt_q == 3'd7) begin
              if (in_pay) begin
                byte_o       <= byte_nxt;
                byte_valid_o <= 1'b1;
                byte_idx_q   <= byte_idx_q + 1'b1;
              end else begin
                frame_end_o <= 1'b1;
                crc_ok_o    <= (byte_nxt == crc_q);
                state_q     <= ST_HUNT;
              end
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/tlg_deframer_chk.sv
module tlg_deframer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sym_valid_i,
  input logic manch_en_i,
  input logic byte_valid_o,
  input logic frame_start_o,
  input logic frame_end_o,
  input logic crc_ok_o,
  input logic abort_o
);
  a_r6_byte_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  a_r6_byte_after_sym: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(sym_valid_i));

  a_r3_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  a_r3_start_after_sym: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(sym_valid_i));

  a_r9_end_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  a_r7_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_o |-> $stable(crc_ok_o));

  a_r8_abort_manch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(manch_en_i) && !frame_end_o && !byte_valid_o);
endmodule

bind tlg_deframer tlg_deframer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sym_valid_i   (sym_valid_i),
  .manch_en_i    (manch_en_i),
  .byte_valid_o  (byte_valid_o),
  .frame_start_o (frame_start_o),
  .frame_end_o   (frame_end_o),
  .crc_ok_o      (crc_ok_o),
  .abort_o       (abort_o)
);

// File: tb/tlg_deframer_bench.sv
module tlg_deframer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sym_i = 1'b0, sym_valid_i = 1'b0;
  logic        manch_en_i = 1'b0, manch_pol_i = 1'b0;
  logic [15:0] wake_min_i = 16'd16;
  logic [31:0] sof_pat_i = 32'hFFFF_CA35;
  logic [5:0]  sof_len_i = 6'd16;
  logic [6:0]  pay_len_i = 7'd1;
  logic [5:0]  crc_skip_i = '0;
  logic [7:0]  crc_init_i = '0;
  logic [7:0]  byte_o;
  logic        byte_valid_o, frame_start_o, frame_end_o, crc_ok_o, abort_o;

  tlg_deframer u_tlg_deframer (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_n = 0, n_start = 0, n_end = 0, n_abort = 0;
  logic       last_ok = 1'b0;
  logic [7:0] tx [64];
  logic [7:0] rx [64];

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    if (byte_valid_o) begin
      if (rx_n < 64) rx[rx_n] = byte_o;
      rx_n++;
    end
    if (frame_start_o) n_start++;
    if (frame_end_o) begin n_end++; last_ok = crc_ok_o; end
    if (abort_o) n_abort++;
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(posedge clk_i);
    rx_n = 0; n_start = 0; n_end = 0; n_abort = 0;
  endtask

  task automatic send_sym(logic b);
    @(negedge clk_i); sym_i = b; sym_valid_i = 1'b1;
    @(negedge clk_i); sym_valid_i = 1'b0;
  endtask

  task automatic send_bit(logic b);
    if (!manch_en_i) send_sym(b);
    else begin
      send_sym(manch_pol_i ? b : ~b);
      send_sym(manch_pol_i ? ~b : b);
    end
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_wake(int n);
    for (int i = 0; i < n; i++) send_sym(i % 2 == 0);
  endtask

  task automatic send_sof(logic flip_last);
    for (int i = int'(sof_len_i) - 1; i >= 0; i--)
      send_sym(sof_pat_i[i] ^ (flip_last && i == 0));
  endtask

  function automatic logic [7:0] ref_crc(int n, int skip, logic [7:0] init);
    logic [7:0] c = init;
    logic b, fb;
    for (int i = 0; i < n * 8; i++) begin
      b = tx[i / 8][7 - (i % 8)];
      if (i >= skip) begin
        fb = c[7] ^ b;
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    end
    return c;
  endfunction

  task automatic t_frame(string req, logic manch, logic pol, int n, int skip,
                         logic [7:0] init, logic bad, int seed);
    manch_en_i = manch; manch_pol_i = pol; pay_len_i = 7'(n);
    crc_skip_i = 6'(skip); crc_init_i = init;
    for (int i = 0; i < n; i++) tx[i] = 8'((i * 37 + seed * 11 + 5) ^ (i << 3));
    clr_mon();
    send_wake(int'(wake_min_i) + 4);
    send_sof(1'b0);
    for (int i = 0; i < n; i++) send_byte(tx[i]);
    send_byte(ref_crc(n, skip, init) ^ (bad ? 8'h5A : 8'h00));
    repeat (4) @(negedge clk_i);
    check("R3", {req, " frame_start count"}, n_start, 1);
    check("R6", {req, " byte count"}, rx_n, n);
    for (int i = 0; i < n && i < rx_n; i++)
      check(manch ? "R5" : "R4", $sformatf("%s byte %0d", req, i), rx[i], tx[i]);
    check("R9", {req, " frame_end count"}, n_end, 1);
    check("R7", {req, " crc_ok"}, last_ok, !bad);
    check("R8", {req, " no abort"}, n_abort, 0);
  endtask

  task automatic t_reset();
    check("R1", "byte_valid after reset", byte_valid_o, 0);
    check("R1", "frame_start after reset", frame_start_o, 0);
    check("R1", "frame_end after reset", frame_end_o, 0);
    check("R1", "abort after reset", abort_o, 0);
    check("R1", "crc_ok after reset", crc_ok_o, 0);
  endtask

  task automatic t_after_end();
    clr_mon();
    send_sym(1'b0); send_sym(1'b0); send_sym(1'b1); send_sym(1'b1);
    for (int i = 0; i < 16; i++) send_sym(i % 3 == 0);
    repeat (4) @(negedge clk_i);
    check("R9", "bytes after frame end", rx_n, 0);
    check("R9", "frame_end after stop", n_end, 0);
  endtask

  task automatic t_violation();
    manch_en_i = 1'b1; manch_pol_i = 1'b0; pay_len_i = 7'd4;
    clr_mon();
    send_wake(int'(wake_min_i) + 2);
    send_sof(1'b0);
    send_byte(8'hA7); send_byte(8'h3C);
    send_sym(1'b1); send_sym(1'b1);
    send_byte(8'h55); send_byte(8'h12);
    repeat (4) @(negedge clk_i);
    check("R8", "abort count", n_abort, 1);
    check("R8", "bytes before abort", rx_n, 2);
    check("R8", "no frame_end", n_end, 0);
  endtask

  task automatic t_short_wake();
    manch_en_i = 1'b0; pay_len_i = 7'd2; wake_min_i = 16'd24;
    clr_mon();
    send_wake(20);
    send_sof(1'b0);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'hF0);
    repeat (4) @(negedge clk_i);
    check("R2", "frame_start after short wake", n_start, 0);
    check("R2", "bytes after short wake", rx_n, 0);
    wake_min_i = 16'd16;
  endtask

  task automatic t_sof_mismatch();
    clr_mon();
    send_wake(int'(wake_min_i) + 4);
    send_sof(1'b1);
    repeat (4) @(negedge clk_i);
    check("R3", "frame_start on wrong pattern", n_start, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_frame("nrz", 1'b0, 1'b0, 3, 0, 8'h00, 1'b0, 1);
    t_after_end();
    t_frame("man_pol0_skip", 1'b1, 1'b0, 4, 12, 8'hFF, 1'b0, 2);
    t_frame("man_pol1", 1'b1, 1'b1, 2, 0, 8'h3A, 1'b0, 3);
    t_frame("bad_crc", 1'b0, 1'b0, 2, 3, 8'h00, 1'b1, 4);
    t_violation();
    t_short_wake();
    t_sof_mismatch();
    sof_len_i = 6'd32; sof_pat_i = 32'hC0DE_F00D;
    t_frame("sof32_len1", 1'b1, 1'b1, 1, 0, 8'h81, 1'b0, 5);
    sof_len_i = 6'd8; sof_pat_i = 32'h0000_00D4;
    t_frame("len64", 1'b0, 1'b0, 64, 63, 8'h00, 1'b0, 6);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule